// File: doc/BRIEF.md
# Serial Systematic CRC Encoder and Checker

This block divides a serial bit stream by a fixed binary generator polynomial, one bit per accepted beat, most significant bit first. In encode mode it forwards a frame of information bits unchanged to its output stream. It then appends the remainder of the information polynomial, multiplied by x to the power of the generator degree and divided by the generator. The resulting codeword is always an exact multiple of the generator. In check mode it consumes a whole received codeword, produces no output stream, and reports whether the division left a nonzero remainder.

The generator degree, the lower coefficients of the generator (the leading and constant terms are implicitly 1), and the number of information bits per frame are parameters. Typical generators are the degree-8 polynomial with terms 8, 2, 1 and 0, the degree-16 polynomial with terms 16, 12, 5 and 0, and the degree-32 polynomial with terms 32, 26, 23, 22, 16, 12, 11, 10, 8, 7, 5, 4, 2, 1 and 0. Every frame has the same length of `K_BITS + DEG` beats. The mode pin is sampled on the first accepted beat of a frame and holds for the whole frame.

Both data streams are valid/ready. An input beat transfers when `in_valid` and `in_ready` are both high. An output beat transfers when `out_valid` and `out_ready` are both high. In the information phase of encode mode, the input is passed combinationally to the output, so `in_ready` follows `out_ready` and `out_valid` follows `in_valid`. In the remainder phase `in_ready` is low, `out_valid` is high, and a stalled output bit stays fixed until it is taken. In check mode `in_ready` is always high and the output stream is idle.

Top module: `crc_serial_codec`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `err_valid` are 0, and with `mode_check`=0 the block is at the start of a frame, so `in_ready` equals `out_ready`.
- R2: In encode mode, during the first `K_BITS` beats of a frame, `out_bit` equals `in_bit`, `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`.
- R3: In encode mode, after the information bits the block emits `DEG` remainder bits, most significant first. With generator x^3+x+1 and information 1100, the frame on `out_bit` is 1100010.
- R4: During the remainder phase `in_ready` is 0, and the values on `in_valid` and `in_bit` have no effect on the emitted bits.
- R5: `out_last` is 1 only on the final remainder beat of an encode frame.
- R6: While a remainder beat is offered and `out_ready` is 0, `out_valid` stays 1 and `out_bit` stays unchanged on the next cycle.
- R7: In check mode, `err_valid` becomes 1 in the cycle after the last codeword bit is accepted. For a valid codeword (for example 1100010 with x^3+x+1), `err_flag` is then 0.
- R8: A received word whose remainder is nonzero, such as any single-bit error, gives `err_flag`=1.
- R9: An error pattern that is itself a nonzero multiple of the generator goes undetected. For example, 1100010 XOR 0001011 = 1101001 gives `err_flag`=0.
- R10: `err_valid` and `err_flag` hold their values until the first beat of the next frame is accepted. In the cycle after that beat, `err_valid` is 0.
- R11: The remainder register is zero at the start of every frame, so the results of back-to-back frames depend only on their own bits.
- R12: The mode is taken from `mode_check` on the first accepted beat of a frame. Changes to `mode_check` later in the frame have no effect.
- R13: In check mode `in_ready` is 1 and `out_valid` is 0 for every beat of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_check | input | 1 | 0 = encode, 1 = check; sampled at frame start |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Block accepts the input bit |
| in_bit | input | 1 | Serial input bit, MSB first |
| out_valid | output | 1 | Output bit offered (encode mode) |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_bit | output | 1 | Serial output bit, MSB first |
| out_last | output | 1 | Final beat of an encoded frame |
| err_valid | output | 1 | Check result available |
| err_flag | output | 1 | Received word had a nonzero remainder |

## Verification
A corrupted remainder register shows up on the ports within one frame. In encode mode it appears as a wrong appended bit within `DEG` beats of the last information bit. In check mode it flips `err_flag` in the cycle after the last received bit. A wrong beat counter shifts the frame boundary, which moves `out_last` and the drop of `in_ready` by whole beats. A stale remainder or a stale mode latched from the previous frame corrupts the next frame, so back-to-back frames and a mid-frame mode change are exercised against remainders the bench computes by long division.

// File: rtl/crc_codec_pkg.sv
package crc_codec_pkg;

  // Which part of an encoded frame is on the wire
  typedef enum logic [1:0] {
    SEG_INFO  = 2'd0,
    SEG_CHECK = 2'd1,
    SEG_RECV  = 2'd2
  } seg_e;

  // Default generator: x^3 + x + 1 (lower coefficients only)
  localparam int unsigned DEF_DEG  = 3;
  localparam int unsigned DEF_INFO = 4;

endpackage

// File: rtl/crc_shift_div.sv
module crc_shift_div #(
  parameter int unsigned DEG = 3,
  parameter logic [DEG-1:0] POLY = 3'b011
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           feed,
  input  logic           shift,
  input  logic           din,
  output logic [DEG-1:0] rem,
  output logic [DEG-1:0] rem_next
);

  logic fb;

  // One division step: the feedback term is the incoming bit plus the
  // current top coefficient; when set, the generator is subtracted.
  always_comb begin
    fb       = din ^ rem[DEG-1];
    rem_next = {rem[DEG-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem <= '0;
    else if (clear)  rem <= '0;
    else if (feed)   rem <= rem_next;
    else if (shift)  rem <= {rem[DEG-2:0], 1'b0};
  end

  AST_FEED_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(feed && shift)); // R4

endmodule

// File: rtl/crc_frame_seq.sv
module crc_frame_seq
  import crc_codec_pkg::*;
#(
  parameter int unsigned K_BITS = 4,
  parameter int unsigned DEG    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_check,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic out_last,
  output logic step,
  output logic frame_first,
  output logic frame_last,
  output logic feed,
  output logic shift,
  output logic chk_mode,
  output seg_e seg
);

  localparam int unsigned N  = K_BITS + DEG;
  localparam int unsigned CW = $clog2(N + 1);
  localparam logic [CW-1:0] K_C    = CW'(K_BITS);
  localparam logic [CW-1:0] LAST_C = CW'(N - 1);

  logic [CW-1:0] cnt;
  logic          mode_q;
  logic          at_start;
  logic          past_info;
  logic          enc_tail;

  always_comb begin
    at_start  = (cnt == '0);
    chk_mode  = at_start ? mode_check : mode_q;
    past_info = (cnt >= K_C);
    enc_tail  = !chk_mode && past_info;

    if (chk_mode)      seg = SEG_RECV;
    else if (enc_tail) seg = SEG_CHECK;
    else               seg = SEG_INFO;

    unique case (seg)
      SEG_RECV: begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        step      = in_valid;
      end
      SEG_CHECK: begin
        in_ready  = 1'b0;
        out_valid = 1'b1;
        step      = out_ready;
      end
      default: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        step      = in_valid && out_ready;
      end
    endcase

    frame_first = step && at_start;
    frame_last  = step && (cnt == LAST_C);
    feed        = step && !enc_tail;
    shift       = step && enc_tail;
    out_last    = enc_tail && (cnt == LAST_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      mode_q <= 1'b0;
    end else if (step) begin
      cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
      if (at_start) mode_q <= mode_check;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_C); // R11
  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_start && !frame_last) |=> $stable(mode_q)); // R12

endmodule

// File: rtl/crc_serial_codec.sv
module crc_serial_codec
  import crc_codec_pkg::*;
#(
  parameter int unsigned K_BITS = DEF_INFO,
  parameter int unsigned DEG    = DEF_DEG,
  parameter logic [DEG-1:0] POLY = 3'b011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_check,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_last,
  output logic err_valid,
  output logic err_flag
);

  logic           step, frame_first, frame_last, feed, shift, chk_mode;
  seg_e           seg;
  logic [DEG-1:0] rem, rem_next;

  crc_frame_seq #(.K_BITS(K_BITS), .DEG(DEG)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_check(mode_check),
    .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last),
    .step(step), .frame_first(frame_first), .frame_last(frame_last),
    .feed(feed), .shift(shift), .chk_mode(chk_mode), .seg(seg)
  );

  crc_shift_div #(.DEG(DEG), .POLY(POLY)) u_div (
    .clk(clk), .rst_n(rst_n), .clear(frame_last), .feed(feed),
    .shift(shift), .din(in_bit), .rem(rem), .rem_next(rem_next)
  );

  always_comb begin
    out_bit = (seg == SEG_CHECK) ? rem[DEG-1] : in_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_flag  <= 1'b0;
    end else if (frame_last && chk_mode) begin
      err_valid <= 1'b1;
      err_flag  <= |rem_next;
    end else if (frame_first) begin
      err_valid <= 1'b0;
      err_flag  <= 1'b0;
    end
  end

  AST_TAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_ready && !out_ready) |=> (out_valid && $stable(out_bit))); // R6
  AST_LAST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> !out_last); // R5
  AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_last && chk_mode) |=> err_valid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !frame_first && !frame_last) |=> (err_valid && $stable(err_flag))); // R10
  AST_CHECK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_RECV) |-> (!out_valid && in_ready)); // R13

endmodule

// File: tb/crc_serial_codec_bench.sv
module crc_serial_codec_bench;

  localparam int unsigned CLK_P  = 10;
  localparam int unsigned K_BITS = 4;
  localparam int unsigned DEG    = 3;
  localparam int unsigned N      = K_BITS + DEG;
  localparam logic [DEG-1:0] POLY = 3'b011;
  localparam logic [DEG:0]   GEN  = {1'b1, POLY};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_check = 1'b0, in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, out_last, err_valid, err_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  crc_serial_codec #(.K_BITS(K_BITS), .DEG(DEG), .POLY(POLY)) u_crc_serial_codec (
    .clk(clk), .rst_n(rst_n), .mode_check(mode_check),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .out_last(out_last), .err_valid(err_valid), .err_flag(err_flag)
  );

  task automatic ck(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // Remainder of info * x^DEG, by long division
  function automatic logic [DEG-1:0] ref_rem(input logic [K_BITS-1:0] info);
    logic [N-1:0] d;
    d = {info, {DEG{1'b0}}};
    for (int i = N - 1; i >= int'(DEG); i--)
      if (d[i]) d[i -: DEG+1] = d[i -: DEG+1] ^ GEN;
    return d[DEG-1:0];
  endfunction

  function automatic logic word_rem_nz(input logic [N-1:0] w);
    logic [N-1:0] d;
    d = w;
    for (int i = N - 1; i >= int'(DEG); i--)
      if (d[i]) d[i -: DEG+1] = d[i -: DEG+1] ^ GEN;
    return |d[DEG-1:0];
  endfunction

  task automatic t_reset();
    @(negedge clk);
    #1;
    ck("R1 out_valid", out_valid, 0);
    ck("R1 out_last", out_last, 0);
    ck("R1 err_valid", err_valid, 0);
    ck("R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_encode(input logic [K_BITS-1:0] info, input bit stall, input bit flip);
    logic [DEG-1:0] r;
    r = ref_rem(info);
    for (int i = K_BITS - 1; i >= 0; i--) begin
      @(negedge clk);
      if (i == int'(K_BITS) - 2) begin
        // upstream gap then downstream stall in the information phase
        in_valid = 1'b0; out_ready = 1'b1; #1;
        ck("R2 out_valid gap", out_valid, 0);
        @(negedge clk);
        in_valid = 1'b1; in_bit = info[i]; out_ready = 1'b0; #1;
        ck("R2 in_ready stall", in_ready, 0);
        @(negedge clk);
      end
      in_valid = 1'b1; in_bit = info[i]; out_ready = 1'b1;
      if (flip && i != int'(K_BITS) - 1) mode_check = 1'b1; // R12
      #1;
      ck("R2 out_valid", out_valid, 1);
      ck("R2 out_bit", out_bit, info[i]);
      ck("R2 in_ready", in_ready, 1);
    end
    for (int j = 0; j < int'(DEG); j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_bit = ~in_bit; // R4: ignored
      if (stall && j == 1) begin
        out_ready = 1'b0; #1;
        ck("R6 valid stalled", out_valid, 1);
        ck("R6 bit stalled", out_bit, r[DEG-1-j]);
        @(negedge clk);
        in_bit = ~in_bit; #1;
        ck("R6 valid held", out_valid, 1);
        ck("R6 bit held", out_bit, r[DEG-1-j]);
      end
      out_ready = 1'b1; #1;
      ck("R3 remainder bit", out_bit, r[DEG-1-j]);
      ck("R3 out_valid", out_valid, 1);
      ck("R4 in_ready low", in_ready, 0);
      ck("R5 out_last", out_last, (j == int'(DEG) - 1));
    end
    @(negedge clk);
    in_valid = 1'b0; mode_check = 1'b0; #1;
    ck("R5 no last after frame", out_last, 0);
    ck("R11 frame restart ready", in_ready, 1);
  endtask

  task automatic t_check(input logic [N-1:0] w, input logic exp_err, input string req);
    for (int i = N - 1; i >= 0; i--) begin
      @(negedge clk);
      mode_check = 1'b1; in_valid = 1'b1; in_bit = w[i]; out_ready = 1'b1; #1;
      ck("R13 in_ready", in_ready, 1);
      ck("R13 out_valid", out_valid, 0);
    end
    @(negedge clk);
    in_valid = 1'b0; mode_check = 1'b0; #1;
    ck("R7 err_valid", err_valid, 1);
    ck(req, err_flag, exp_err);
  endtask

  task automatic t_hold();
    logic [N-1:0] w;
    w = 7'b1010011;
    t_check(w, word_rem_nz(w), "R8 err_flag");
    repeat (3) @(negedge clk);
    #1;
    ck("R10 err_valid held", err_valid, 1);
    ck("R10 err_flag held", err_flag, word_rem_nz(w));
    in_valid = 1'b1; in_bit = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; #1;
    ck("R10 err_valid cleared", err_valid, 0);
    // finish that encode frame (info 1xxx with zeros)
    for (int i = 0; i < int'(K_BITS) - 1; i++) begin
      in_valid = 1'b1; in_bit = 1'b0; @(negedge clk);
    end
    in_valid = 1'b0;
    for (int j = 0; j < int'(DEG); j++) @(negedge clk);
    #1;
    ck("R11 idle after drain", out_valid, 0);
  endtask

  initial begin
    t_reset();
    t_encode(4'b1100, 1'b0, 1'b0);           // R3 example: 1100010
    ck("R3 example remainder", ref_rem(4'b1100), 3'b010);
    t_encode(4'b1011, 1'b1, 1'b0);           // R6, R11 back-to-back
    t_encode(4'b0111, 1'b0, 1'b1);           // R12 mode changed mid-frame
    t_check(7'b1100010, 1'b0, "R7 valid codeword");
    t_check(7'b1100000, 1'b1, "R8 single-bit error");
    t_check(7'b1101001, 1'b0, "R9 multiple of generator");
    t_check({4'b1011, ref_rem(4'b1011)}, 1'b0, "R11 second codeword");
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule